// File: doc/BRIEF.md
# Product-Term Allocator Ring

This block is the combinational heart of one function block in a small programmable logic array. A vector of input signals feeds an AND plane. Each product term can use the true form, the complement form, or both, of every input. The product terms are grouped five to a site, and the sites are arranged in a ring. A per-term configuration word gives each term one role. It can feed its own site's OR sum, drive the special-function signal tied to its slot, or be exported. An exported term travels to a neighbouring site in the configured direction, and it can ride through any number of passing sites around the ring until a site absorbs it into its sum.

Each site's OR sum goes through an XOR stage. The second leg of that XOR is either the site's fifth term or a configured polarity bit. The result is a sum-of-products output. Each site also gives an output-enable, a clock, a set and a reset term. Configuration arrives serially into a shadow register and becomes active only on a load strobe. Illegal configurations raise an error flag and lose the terms involved. All outputs are registered.

Top module: `pterm_ring_block`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge. The active configuration resets to all zeros: every term is local with an empty mask, so it reads 1, every `sop_out` bit reads 1, the four special outputs read 0 and `cfg_err` reads 0.
- R2: A product term is the AND of the inputs selected by its true mask and the inverses of the inputs selected by its complement mask. A term with both masks empty reads 1. A term that selects both forms of one input reads 0.
- R3: Each term word holds five fields. Bit 0 is special, bit 1 is export and bit 2 is direction. The true mask starts at bit 3. The complement mask follows it. A term with special and export both clear adds to its own site's OR sum.
- R4: A term with special set and export clear drives the special signal given by its slot within the site: slot 0 output enable, slot 1 clock, slot 2 set, slot 3 reset, slot 4 the XOR leg. A special output whose slot term is not special reads 0.
- R5: A term with export set and special clear leaves its site toward the next higher index when direction is 1, and toward the next lower index when direction is 0. Each site word holds three bits: bit 0 passes the upward chain, bit 1 passes the downward chain, and bit 2 is polarity. A site whose pass bit for a chain is clear absorbs that chain into its OR sum. A site whose pass bit is set forwards the chain to the next site.
- R6: The ring is circular. The highest site forwards upward into site 0, and site 0 forwards downward into the highest site. A chain can come back to the site it left.
- R7: With every other site exporting and passing, a single site collects every product term of the block.
- R8: `sop_out` of a site equals its OR sum XOR a leg. The leg is the slot-4 term when that term is special, and the site's polarity bit otherwise.
- R9: Configuration bits shift in on `cfg_sdi` while `cfg_shift` is high, and the first bit sent lands in the most significant position. Term words lie from index 0 at the bottom, and site words lie above them. Shifting alone changes no output. A `cfg_load` pulse makes the shifted image active.
- R10: A term with both special and export set is illegal. It contributes to no sum, chain or special output, and it raises `cfg_err`.
- R11: If every site passes the upward chain, or every site passes the downward chain, `cfg_err` is raised and terms exported in that direction reach no site.
- R12: All outputs are registered. A change on `in_vec` appears one clock edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | N_IN | Signals feeding the AND plane |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift enable for the configuration shadow |
| cfg_load | input | 1 | Copies the shadow into the active configuration |
| sop_out | output | N_SITE | Per-site sum-of-products after the XOR stage |
| pt_oe | output | N_SITE | Per-site output-enable term |
| pt_clk | output | N_SITE | Per-site clock term |
| pt_set | output | N_SITE | Per-site set term |
| pt_rst | output | N_SITE | Per-site reset term |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The hardest case to reach is a single term that crosses many passing sites and wraps past the ends of the ring before it is absorbed. Random configurations almost never line up every pass bit that such a path needs. Directed runs therefore fix one collecting site and make all other sites export and pass. They then light one remote term at a time, each with a chosen direction, so that every term in the block is shown to arrive, including the paths that wrap. Random configurations with sparse masks, mixed roles and occasional closed rings are also compared against a walk-based reference model. These mixed runs also cover configurations that are illegal.

// File: rtl/pta_pkg.sv
package pta_pkg;
  // native terms per site and the slot that owns each special role
  localparam int NAT       = 5;
  localparam int SLOT_OE   = 0;
  localparam int SLOT_CLK  = 1;
  localparam int SLOT_SET  = 2;
  localparam int SLOT_RST  = 3;
  localparam int SLOT_XOR  = 4;

  // field offsets inside one term word
  localparam int TF_SPEC   = 0;
  localparam int TF_EXP    = 1;
  localparam int TF_DIR    = 2;
  localparam int TF_MASK   = 3;

  // field offsets inside one site word
  localparam int SF_PASS_UP = 0;
  localparam int SF_PASS_DN = 1;
  localparam int SF_POL     = 2;
  localparam int SITE_W     = 3;

  function automatic int term_width(input int n_in);
    return 2 * n_in + TF_MASK;
  endfunction
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  input  logic             shift_en,
  input  logic             load,
  output logic [CFG_W-1:0] active
);
  logic [CFG_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (shift_en) shadow <= {shadow[CFG_W-2:0], sdi};
      if (load)     active <= shadow;
    end
  end
endmodule

// File: rtl/pta_site_alloc.sv
module pta_site_alloc import pta_pkg::*; #(
  parameter int N_IN = 8,
  localparam int TW  = term_width(N_IN)
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [NAT*TW-1:0] term_cfg,
  output logic              local_or,
  output logic              exp_up,
  output logic              exp_dn,
  output logic [NAT-1:0]    spec_val,
  output logic [NAT-1:0]    spec_sel,
  output logic              bad
);
  logic [NAT-1:0] loc_v, up_v, dn_v, bad_v;

  for (genvar k = 0; k < NAT; k++) begin : g_term
    localparam int B = k * TW;
    logic [N_IN-1:0] tmask, cmask;
    logic sp, ex, dr, tv, ok;
    assign sp    = term_cfg[B + TF_SPEC];
    assign ex    = term_cfg[B + TF_EXP];
    assign dr    = term_cfg[B + TF_DIR];
    assign tmask = term_cfg[B + TF_MASK +: N_IN];
    assign cmask = term_cfg[B + TF_MASK + N_IN +: N_IN];
    // product of selected literals; empty product is 1
    assign tv    = &((~tmask | in_vec) & (~cmask | ~in_vec));
    assign ok    = ~(sp & ex);
    assign bad_v[k]    = sp & ex;
    assign loc_v[k]    = ~sp & ~ex & tv;
    assign spec_sel[k] = sp & ok;
    assign spec_val[k] = sp & ok & tv;
    assign up_v[k]     = ex & ok & dr & tv;
    assign dn_v[k]     = ex & ok & ~dr & tv;
  end

  assign local_or = |loc_v;
  assign exp_up   = |up_v;
  assign exp_dn   = |dn_v;
  assign bad      = |bad_v;
endmodule

// File: rtl/pta_cascade.sv
module pta_cascade #(
  parameter int N_SITE = 18
) (
  input  logic [N_SITE-1:0] exp_up,
  input  logic [N_SITE-1:0] exp_dn,
  input  logic [N_SITE-1:0] pass_up,
  input  logic [N_SITE-1:0] pass_dn,
  output logic [N_SITE-1:0] feed
);
  logic [N_SITE-1:0] up_in, dn_in;

  // Each site sees the nearest exporters behind it, gated by the pass bits
  // of the sites in between; written as a prefix so no ring loop exists.
  always_comb begin
    logic acc_u, run_u, acc_d, run_d;
    for (int i = 0; i < N_SITE; i++) begin
      acc_u = 1'b0; run_u = 1'b1;
      acc_d = 1'b0; run_d = 1'b1;
      for (int j = 1; j <= N_SITE; j++) begin
        acc_u = acc_u | (run_u & exp_up[(i - j + N_SITE) % N_SITE]);
        run_u = run_u & pass_up[(i - j + N_SITE) % N_SITE];
        acc_d = acc_d | (run_d & exp_dn[(i + j) % N_SITE]);
        run_d = run_d & pass_dn[(i + j) % N_SITE];
      end
      up_in[i] = acc_u;
      dn_in[i] = acc_d;
    end
  end

  assign feed = (~pass_up & up_in) | (~pass_dn & dn_in);
endmodule

// File: rtl/pterm_ring_block.sv
module pterm_ring_block import pta_pkg::*; #(
  parameter int N_IN   = 54,
  parameter int N_SITE = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   in_vec,
  input  logic              cfg_sdi,
  input  logic              cfg_shift,
  input  logic              cfg_load,
  output logic [N_SITE-1:0] sop_out,
  output logic [N_SITE-1:0] pt_oe,
  output logic [N_SITE-1:0] pt_clk,
  output logic [N_SITE-1:0] pt_set,
  output logic [N_SITE-1:0] pt_rst,
  output logic              cfg_err
);
  localparam int N_T       = N_SITE * NAT;
  localparam int TW        = term_width(N_IN);
  localparam int SITE_BASE = N_T * TW;
  localparam int CFG_W     = SITE_BASE + N_SITE * SITE_W;

  logic [CFG_W-1:0] cfg_act;
  logic [N_SITE-1:0] loc_or, exp_up, exp_dn, bad, feed;
  logic [N_SITE-1:0] pass_up, pass_dn, pol;
  logic [N_SITE-1:0][NAT-1:0] spec_val, spec_sel;
  logic [N_SITE-1:0] sop_c, oe_c, clk_c, set_c, rst_c;
  logic err_c;

  pta_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .sdi(cfg_sdi), .shift_en(cfg_shift),
    .load(cfg_load), .active(cfg_act)
  );

  for (genvar s = 0; s < N_SITE; s++) begin : g_site
    localparam int SB = SITE_BASE + s * SITE_W;
    assign pass_up[s] = cfg_act[SB + SF_PASS_UP];
    assign pass_dn[s] = cfg_act[SB + SF_PASS_DN];
    assign pol[s]     = cfg_act[SB + SF_POL];

    pta_site_alloc #(.N_IN(N_IN)) u_alloc (
      .in_vec(in_vec),
      .term_cfg(cfg_act[s*NAT*TW +: NAT*TW]),
      .local_or(loc_or[s]), .exp_up(exp_up[s]), .exp_dn(exp_dn[s]),
      .spec_val(spec_val[s]), .spec_sel(spec_sel[s]), .bad(bad[s])
    );

    assign sop_c[s] = (loc_or[s] | feed[s]) ^
                      (spec_sel[s][SLOT_XOR] ? spec_val[s][SLOT_XOR] : pol[s]);
    assign oe_c[s]  = spec_val[s][SLOT_OE];
    assign clk_c[s] = spec_val[s][SLOT_CLK];
    assign set_c[s] = spec_val[s][SLOT_SET];
    assign rst_c[s] = spec_val[s][SLOT_RST];
  end

  pta_cascade #(.N_SITE(N_SITE)) u_ring (
    .exp_up(exp_up), .exp_dn(exp_dn),
    .pass_up(pass_up), .pass_dn(pass_dn), .feed(feed)
  );

  assign err_c = (|bad) | (&pass_up) | (&pass_dn);

  always_ff @(posedge clk) begin
    if (rst) begin
      sop_out <= '0;
      pt_oe   <= '0;
      pt_clk  <= '0;
      pt_set  <= '0;
      pt_rst  <= '0;
      cfg_err <= 1'b0;
    end else begin
      sop_out <= sop_c;
      pt_oe   <= oe_c;
      pt_clk  <= clk_c;
      pt_set  <= set_c;
      pt_rst  <= rst_c;
      cfg_err <= err_c;
    end
  end
endmodule

// File: rtl/pta_ring_chk.sv
module pta_ring_chk import pta_pkg::*; #(
  parameter int N_IN   = 54,
  parameter int N_SITE = 18,
  parameter int N_T    = 90,
  parameter int TW     = 111,
  parameter int SB     = 9990,
  parameter int CFG_W  = 10044
) (
  input logic              clk,
  input logic              rst,
  input logic [N_IN-1:0]   in_vec,
  input logic              cfg_load,
  input logic [CFG_W-1:0]  cfg_act,
  input logic [N_SITE-1:0] sop_out,
  input logic              cfg_err
);
  logic [N_SITE-1:0] pu, pd;
  logic conflict;

  for (genvar s = 0; s < N_SITE; s++) begin : g_p
    assign pu[s] = cfg_act[SB + s*SITE_W + SF_PASS_UP];
    assign pd[s] = cfg_act[SB + s*SITE_W + SF_PASS_DN];
  end

  always_comb begin
    conflict = 1'b0;
    for (int t = 0; t < N_T; t++)
      conflict = conflict | (cfg_act[t*TW + TF_SPEC] & cfg_act[t*TW + TF_EXP]);
  end

  // R1: a reset edge leaves the outputs cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sop_out == '0 && cfg_err == 1'b0));

  // R9: the active image only moves on a load pulse
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_act));

  // R10: a doubly-claimed term is flagged
  a_r10_conflict_flag: assert property (@(posedge clk) disable iff (rst)
    conflict |=> cfg_err);

  // R11: a ring with no absorbing site is flagged
  a_r11_loop_flag: assert property (@(posedge clk) disable iff (rst)
    (&pu || &pd) |=> cfg_err);

  // R12: outputs follow only registered inputs and configuration
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(in_vec) && $stable(cfg_act) && !$past(rst)) |=> $stable(sop_out));
endmodule

bind pterm_ring_block pta_ring_chk #(
  .N_IN(N_IN), .N_SITE(N_SITE), .N_T(N_T), .TW(TW), .SB(SITE_BASE), .CFG_W(CFG_W)
) i_chk (
  .clk(clk), .rst(rst), .in_vec(in_vec), .cfg_load(cfg_load),
  .cfg_act(cfg_act), .sop_out(sop_out), .cfg_err(cfg_err)
);

// File: tb/test_pterm_ring_block.sv
module test_pterm_ring_block;
  localparam int N_IN   = 6;
  localparam int N_SITE = 6;
  localparam int NAT    = 5;
  localparam int N_T    = N_SITE * NAT;
  localparam int TW     = 2 * N_IN + 3;
  localparam int SB     = N_T * TW;
  localparam int CW     = SB + N_SITE * 3;
  localparam int EW     = 5 * N_SITE + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] in_vec = '0;
  logic cfg_sdi = 1'b0, cfg_shift = 1'b0, cfg_load = 1'b0;
  logic [N_SITE-1:0] sop_out, pt_oe, pt_clk, pt_set, pt_rst;
  logic cfg_err;
  logic [EW-1:0] got;
  logic [CW-1:0] cfg = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pterm_ring_block #(.N_IN(N_IN), .N_SITE(N_SITE)) i_pterm_ring_block (
    .clk(clk), .rst(rst), .in_vec(in_vec), .cfg_sdi(cfg_sdi),
    .cfg_shift(cfg_shift), .cfg_load(cfg_load), .sop_out(sop_out),
    .pt_oe(pt_oe), .pt_clk(pt_clk), .pt_set(pt_set), .pt_rst(pt_rst),
    .cfg_err(cfg_err)
  );

  assign got = {cfg_err, pt_rst, pt_set, pt_clk, pt_oe, sop_out};

  function automatic void set_term(int t, bit sp, bit ex, bit dr,
                                   logic [N_IN-1:0] tm, logic [N_IN-1:0] cm);
    cfg[t*TW + 0] = sp;
    cfg[t*TW + 1] = ex;
    cfg[t*TW + 2] = dr;
    cfg[t*TW + 3 +: N_IN] = tm;
    cfg[t*TW + 3 + N_IN +: N_IN] = cm;
  endfunction

  function automatic void set_site(int s, bit pu, bit pd, bit pl);
    cfg[SB + s*3 + 0] = pu;
    cfg[SB + s*3 + 1] = pd;
    cfg[SB + s*3 + 2] = pl;
  endfunction

  // every term local and constantly 0 (x0 & ~x0), no passing, no inversion
  function automatic void clear_all();
    cfg = '0;
    for (int t = 0; t < N_T; t++) set_term(t, 0, 0, 0, 1, 1);
  endfunction

  // reference: evaluate each term, then walk exported terms around the ring
  function automatic logic [EW-1:0] ref_out(logic [CW-1:0] c, logic [N_IN-1:0] x);
    logic [N_SITE-1:0] sm, dl, oe, ck, st, rs, pu, pd, leg;
    logic er;
    bit sp, ex, dr, tv, done;
    int base, cur;
    sm = '0; dl = '0; oe = '0; ck = '0; st = '0; rs = '0;
    for (int s = 0; s < N_SITE; s++) begin
      pu[s]  = c[SB + s*3 + 0];
      pd[s]  = c[SB + s*3 + 1];
      leg[s] = c[SB + s*3 + 2];
    end
    er = (&pu) | (&pd);
    for (int s = 0; s < N_SITE; s++) begin
      for (int k = 0; k < NAT; k++) begin
        base = (s*NAT + k) * TW;
        sp = c[base]; ex = c[base+1]; dr = c[base+2];
        tv = 1;
        for (int b = 0; b < N_IN; b++) begin
          if (c[base+3+b] && !x[b]) tv = 0;
          if (c[base+3+N_IN+b] && x[b]) tv = 0;
        end
        if (sp && ex) er = 1'b1;
        else if (!sp && !ex) sm[s] = sm[s] | tv;
        else if (sp) begin
          case (k)
            0: oe[s] = tv;
            1: ck[s] = tv;
            2: st[s] = tv;
            3: rs[s] = tv;
            default: leg[s] = tv;
          endcase
        end else begin
          cur = s; done = 0;
          for (int step = 1; step <= N_SITE; step++) begin
            if (!done) begin
              cur = dr ? (cur + 1) % N_SITE : (cur + N_SITE - 1) % N_SITE;
              if (!(dr ? pu[cur] : pd[cur])) begin
                dl[cur] = dl[cur] | tv;
                done = 1;
              end
            end
          end
        end
      end
    end
    return {er, rs, st, ck, oe, (sm | dl) ^ leg};
  endfunction

  task automatic check(logic [EW-1:0] g, logic [EW-1:0] e, string tag);
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  task automatic check1(logic g, logic e, string tag);
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, g, e);
    end
  endtask

  task automatic shift_cfg(logic [CW-1:0] c);
    for (int b = CW - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_sdi = c[b];
      cfg_shift = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic load_cfg();
    cfg_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic program_cfg();
    shift_cfg(cfg);
    load_cfg();
  endtask

  // called at a negedge; returns at a negedge with outputs settled
  task automatic apply(logic [N_IN-1:0] x, string tag);
    in_vec = x;
    @(posedge clk);
    @(negedge clk);
    check(got, ref_out(cfg, x), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] keep, other;
    logic [N_IN-1:0] xv;
    int hot;
    void'($urandom(32'd9157));

    // R1: outputs cleared under reset, then default image
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(got, '0, "R1 reset state");
    rst = 1'b0;
    apply(6'h2b, "R1 default image");

    // R2: literal selection
    clear_all();
    set_term(0, 0, 0, 0, 6'b000001, 6'b000010);
    program_cfg();
    for (int v = 0; v < 4; v++) apply(N_IN'(v), "R2 literal product");
    set_term(0, 0, 0, 0, 6'b000000, 6'b000000);
    program_cfg();
    apply(6'h00, "R2 empty product");

    // R4: each slot drives its own special output
    clear_all();
    for (int k = 0; k < NAT; k++) set_term(NAT + k, 1, 0, 0, N_IN'(1 << k), 0);
    program_cfg();
    apply(6'h05, "R4 special slots");
    apply(6'h1a, "R4 special slots");
    check1(pt_clk[1], 1'b1, "R4 clock slot");
    check1(pt_oe[1], 1'b0, "R4 enable slot");

    // R8: polarity constant and term-driven leg
    clear_all();
    set_site(0, 0, 0, 1);
    set_term(NAT + 4, 1, 0, 0, 6'b000001, 0);
    set_term(NAT + 0, 0, 0, 0, 6'b000010, 0);
    program_cfg();
    for (int v = 0; v < 4; v++) begin
      apply(N_IN'(v), "R8 polarity");
      check1(sop_out[1], v[0] ^ v[1], "R8 xor leg");
      check1(sop_out[0], 1'b1, "R8 inverted empty sum");
    end

    // R5 R6 R7: site 2 collects; every remote term lit one at a time
    for (int s = 0; s < N_SITE; s++) begin
      if (s == 2) continue;
      for (int k = 0; k < NAT; k++) begin
        clear_all();
        for (int s2 = 0; s2 < N_SITE; s2++) begin
          if (s2 == 2) continue;
          set_site(s2, 1, 1, 0);
          for (int k2 = 0; k2 < NAT; k2++)
            set_term(s2*NAT + k2, 0, 1, (s2 % 2 == 0), 1, 1);
        end
        hot = s*NAT + k;
        set_term(hot, 0, 1, (k % 2 == 1), 0, 0);
        program_cfg();
        apply(N_IN'($urandom), "R7 collect all terms");
        check1(sop_out[2], 1'b1, "R6 ring delivery to collector");
      end
    end

    // R11: upward ring with no absorber
    clear_all();
    for (int s = 0; s < N_SITE; s++) set_site(s, 1, 0, 0);
    set_term(3*NAT, 0, 1, 1, 0, 0);
    program_cfg();
    apply(6'h00, "R11 closed ring");
    check1(cfg_err, 1'b1, "R11 error flag");
    check1(|sop_out, 1'b0, "R11 term dropped");

    // R10: special and export on one term
    clear_all();
    set_term(1, 1, 1, 0, 0, 0);
    program_cfg();
    apply(6'h3f, "R10 double claim");
    check1(pt_clk[0], 1'b0, "R10 term inactive");
    check1(cfg_err, 1'b1, "R10 error flag");

    // R9: shifting without load keeps the old image
    clear_all();
    set_term(4*NAT + 2, 0, 0, 0, 6'b000100, 0);
    program_cfg();
    apply(6'h04, "R9 first image");
    keep = cfg;
    clear_all();
    set_site(4, 0, 0, 1);
    other = cfg;
    cfg = keep;
    shift_cfg(other);
    apply(6'h04, "R9 shift without load");
    apply(6'h00, "R9 shift without load");
    load_cfg();
    cfg = other;
    apply(6'h04, "R9 after load");

    // R12: one edge of latency
    cfg = keep;
    program_cfg();
    apply(6'h04, "R12 before change");
    in_vec = 6'h00;
    #2;
    check(got, ref_out(cfg, 6'h04), "R12 no early change");
    @(posedge clk);
    @(negedge clk);
    check(got, ref_out(cfg, 6'h00), "R12 one edge later");

    // R3 R5: random images and inputs
    for (int n = 0; n < 25; n++) begin
      cfg = '0;
      for (int t = 0; t < N_T; t++) begin
        logic [31:0] r;
        r = $urandom;
        set_term(t, r[1:0] == 2'b00, r[3:2] == 2'b00, r[4],
                 N_IN'($urandom & $urandom & $urandom),
                 N_IN'($urandom & $urandom & $urandom));
      end
      for (int s = 0; s < N_SITE; s++)
        set_site(s, ($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 2 == 0);
      program_cfg();
      for (int v = 0; v < 6; v++) begin
        xv = N_IN'($urandom);
        apply(xv, "R3 R5 random image");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule